// File: doc/BRIEF.md
# Per-Eye Duobinary Symbol Error Counter

This block scores a three-level (duobinary) receiver against the transmitted channel bits. In every cycle it takes a word of transmitted channel bits and a word of slicer decisions. The slicer decisions come as one upper-comparator bit and one lower-comparator bit per lane. The transmitted word first passes through a programmable word delay, so that it lines up with the receive path. The expected level of each symbol is then the sum of its own channel bit and the bit before it. Each symbol is charged to the upper eye, the lower eye, or both, according to that expected level. This gives separate error and opportunity counts, and so a symbol error rate for each eye. A decoded-bit error count runs beside them.

Counting is gated by a run input. A programmable number of leading bits is skipped while receiver adaptation settles. All counters saturate. A snapshot strobe copies every live counter into the output registers in one cycle. A clear input restarts the live counters and the skip window.

Top module: `dbe_eye_counter`

## Requirements
- R1: Lane 0 of a word is the earliest bit. The expected level of a lane is its aligned channel bit plus the previous aligned bit, giving 0, 1 or 2. For lane 0 the previous bit is the last lane of the previous cycle's aligned word, and that bit is 0 after reset.
- R2: A counted symbol whose expected level is 1 or 2 adds one upper-eye opportunity. It adds one upper-eye error when the upper slicer bit differs from (level == 2).
- R3: A counted symbol whose expected level is 0 or 1 adds one lower-eye opportunity. It adds one lower-eye error when the lower slicer bit differs from (level >= 1).
- R4: Every counted symbol is decoded as upper XOR lower. It adds one bit error when that decoded bit differs from (level == 1), which is the original data bit before precoding.
- R5: The receive word of cycle t is compared with the transmitted word of cycle t-D, where D (0 to 63) is the delay input. Delay history is zero after reset.
- R6: Counted bits are numbered from 0 in the order they arrive since the last clear or reset. A bit whose number is below the skip value is not counted. This works with single-bit resolution inside a word.
- R7: While run is low, no live counter changes and the bit numbering does not advance.
- R8: Each live counter saturates at its all-ones value and never wraps.
- R9: A snapshot pulse loads the outputs with the live counts as they stood before that cycle's word. The outputs hold their value in every cycle without a snapshot.
- R10: Clear zeroes the live counters and the bit numbering, and no word is counted in that cycle. The output registers are untouched. A snapshot in the same cycle captures the pre-clear counts.
- R11: Reset zeroes all outputs, live counters, delay history and bit numbering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Zero live counters and bit numbering |
| run | input | 1 | Count enable |
| snap | input | 1 | Copy live counters to outputs |
| align_dly | input | DLY_W | Transmit-path delay in words |
| skip_bits | input | SKIP_W | Number of leading bits excluded |
| tx_bits | input | LANES | Transmitted channel bits, lane 0 earliest |
| slc_hi | input | LANES | Upper slicer decisions |
| slc_lo | input | LANES | Lower slicer decisions |
| up_err_cnt | output | CNT_W | Upper-eye error count |
| up_opp_cnt | output | CNT_W | Upper-eye opportunity count |
| lo_err_cnt | output | CNT_W | Lower-eye error count |
| lo_opp_cnt | output | CNT_W | Lower-eye opportunity count |
| bit_err_cnt | output | CNT_W | Decoded bit error count |

## Verification
Some internal faults leave the outputs unchanged until the next snapshot: a wrong delay tap, a lost previous-bit register, or a skip comparison that is off by one lane. After that snapshot they show up as opportunity counts that differ from the arithmetic expectation, or as error counts on a stream that was sent clean. A carried-bit fault at lane 0 moves the level of roughly one symbol per word, so a few hundred words give a clear difference. Gating, clear and snapshot faults are visible at the very next snapshot, as counts that moved when they should have held or that failed to return to zero. Saturation faults show as small wrapped values after a long all-error run.

// File: rtl/dbe_pkg.sv
package dbe_pkg;
  localparam int IDX_UP_ERR  = 0;
  localparam int IDX_UP_OPP  = 1;
  localparam int IDX_LO_ERR  = 2;
  localparam int IDX_LO_OPP  = 3;
  localparam int IDX_BIT_ERR = 4;
  localparam int NUM_CNT     = 5;

  // expected duobinary level from a channel bit and its predecessor
  function automatic logic [1:0] sym_level(input logic cur, input logic prev);
    return {1'b0, cur} + {1'b0, prev};
  endfunction

  // ideal upper comparator output for a level
  function automatic logic hi_wanted(input logic [1:0] lvl);
    return lvl == 2'd2;
  endfunction

  // ideal lower comparator output for a level
  function automatic logic lo_wanted(input logic [1:0] lvl);
    return lvl != 2'd0;
  endfunction

  // levels that exercise each eye
  function automatic logic in_upper_eye(input logic [1:0] lvl);
    return lvl != 2'd0;
  endfunction

  function automatic logic in_lower_eye(input logic [1:0] lvl);
    return lvl != 2'd2;
  endfunction

  // de-precoded data bit from the two comparators
  function automatic logic decode_bit(input logic hi, input logic lo);
    return hi ^ lo;
  endfunction
endpackage

// File: rtl/dbe_align.sv
module dbe_align #(
  parameter int W     = 4,
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] dly,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout
);
  localparam int DEPTH = (1 << DLY_W) - 1;

  logic [W-1:0] pipe [1:DEPTH];
  logic         primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 1; k <= DEPTH; k++) pipe[k] <= '0;
      primed <= 1'b0;
    end else begin
      pipe[1] <= din;
      for (int k = 2; k <= DEPTH; k++) pipe[k] <= pipe[k-1];
      primed <= 1'b1;
    end
  end

  always_comb begin
    dout = din;
    if (dly != '0) dout = pipe[dly];
  end

  AST_ONE_WORD_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && dly == DLY_W'(1) && $past(dly) == DLY_W'(1)) |-> (dout == $past(din))); // R5
endmodule

// File: rtl/dbe_lane.sv
module dbe_lane
  import dbe_pkg::*;
(
  input  logic cur_bit,
  input  logic prev_bit,
  input  logic hi_bit,
  input  logic lo_bit,
  input  logic qual,
  output logic up_opp,
  output logic up_err,
  output logic lo_opp,
  output logic lo_err,
  output logic bit_err
);
  logic [1:0] lvl;

  always_comb begin
    lvl     = sym_level(cur_bit, prev_bit);
    up_opp  = qual && in_upper_eye(lvl);
    up_err  = up_opp && (hi_bit != hi_wanted(lvl));
    lo_opp  = qual && in_lower_eye(lvl);
    lo_err  = lo_opp && (lo_bit != lo_wanted(lvl));
    bit_err = qual && (decode_bit(hi_bit, lo_bit) != (lvl == 2'd1));
  end
endmodule

// File: rtl/dbe_satcnt.sv
module dbe_satcnt #(
  parameter int CW = 48,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [IW-1:0] inc,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW:0] sum;
  assign sum = {1'b0, cnt} + {{(CW+1-IW){1'b0}}, inc};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (sum[CW]) cnt <= CMAX;
    else             cnt <= sum[CW-1:0];
  end

  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CMAX && !clr) |=> (cnt == CMAX)); // R8
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr) |=> (cnt >= $past(cnt))); // R8
endmodule

// File: rtl/dbe_eye_counter.sv
module dbe_eye_counter
  import dbe_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int CNT_W  = 48,
  parameter int DLY_W  = 6,
  parameter int SKIP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic              snap,
  input  logic [DLY_W-1:0]  align_dly,
  input  logic [SKIP_W-1:0] skip_bits,
  input  logic [LANES-1:0]  tx_bits,
  input  logic [LANES-1:0]  slc_hi,
  input  logic [LANES-1:0]  slc_lo,
  output logic [CNT_W-1:0]  up_err_cnt,
  output logic [CNT_W-1:0]  up_opp_cnt,
  output logic [CNT_W-1:0]  lo_err_cnt,
  output logic [CNT_W-1:0]  lo_opp_cnt,
  output logic [CNT_W-1:0]  bit_err_cnt
);
  localparam int IW = $clog2(LANES + 1);
  localparam int SW = SKIP_W + 1;
  localparam logic [SW-1:0] SEEN_MAX = '1;

  // aligned transmit stream and carried bit
  logic [LANES-1:0] aligned;
  logic             prev_last;

  dbe_align #(.W(LANES), .DLY_W(DLY_W)) u_align (
    .clk  (clk),
    .rst_n(rst_n),
    .dly  (align_dly),
    .din  (tx_bits),
    .dout (aligned)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_last <= 1'b0;
    else        prev_last <= aligned[LANES-1];
  end

  // bit numbering for the skip window
  logic [SW-1:0] seen;
  logic [SW:0]   seen_add;
  assign seen_add = {1'b0, seen} + (SW+1)'(LANES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen <= '0;
    else if (clr)       seen <= '0;
    else if (run)       seen <= seen_add[SW] ? SEEN_MAX : seen_add[SW-1:0];
  end

  // per-lane classification
  logic [LANES-1:0] qual, prev_vec;
  logic [LANES-1:0] l_uo, l_ue, l_lo, l_le, l_be;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (i == 0) begin : g_first
        assign prev_vec[i] = prev_last;
      end else begin : g_rest
        assign prev_vec[i] = aligned[i-1];
      end
      assign qual[i] = run && !clr &&
                       (({1'b0, seen} + (SW+1)'(i)) >= {2'b0, skip_bits});
      dbe_lane u_lane (
        .cur_bit (aligned[i]),
        .prev_bit(prev_vec[i]),
        .hi_bit  (slc_hi[i]),
        .lo_bit  (slc_lo[i]),
        .qual    (qual[i]),
        .up_opp  (l_uo[i]),
        .up_err  (l_ue[i]),
        .lo_opp  (l_lo[i]),
        .lo_err  (l_le[i]),
        .bit_err (l_be[i])
      );
    end
  endgenerate

  // per-word increments, named for the checks below
  logic [IW-1:0] n_uo, n_ue, n_lo, n_le, n_be;
  always_comb begin
    n_uo = '0; n_ue = '0; n_lo = '0; n_le = '0; n_be = '0;
    for (int i = 0; i < LANES; i++) begin
      n_uo = n_uo + IW'(l_uo[i]);
      n_ue = n_ue + IW'(l_ue[i]);
      n_lo = n_lo + IW'(l_lo[i]);
      n_le = n_le + IW'(l_le[i]);
      n_be = n_be + IW'(l_be[i]);
    end
  end

  logic [NUM_CNT-1:0][IW-1:0]    incs;
  logic [NUM_CNT-1:0][CNT_W-1:0] live;
  logic [NUM_CNT-1:0][CNT_W-1:0] held;

  always_comb begin
    incs[IDX_UP_ERR]  = n_ue;
    incs[IDX_UP_OPP]  = n_uo;
    incs[IDX_LO_ERR]  = n_le;
    incs[IDX_LO_OPP]  = n_lo;
    incs[IDX_BIT_ERR] = n_be;
  end

  generate
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
      dbe_satcnt #(.CW(CNT_W), .IW(IW)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .inc  (incs[k]),
        .cnt  (live[k])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held <= '0;
    else if (snap) held <= live;
  end

  assign up_err_cnt  = held[IDX_UP_ERR];
  assign up_opp_cnt  = held[IDX_UP_OPP];
  assign lo_err_cnt  = held[IDX_LO_ERR];
  assign lo_opp_cnt  = held[IDX_LO_OPP];
  assign bit_err_cnt = held[IDX_BIT_ERR];

  AST_ERR_WITHIN_OPP: assert property (@(posedge clk) disable iff (!rst_n)
    (n_ue <= n_uo) && (n_le <= n_lo)); // R2, R3
  AST_SKIP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (seen_add <= {2'b0, skip_bits})) |-> (n_uo == '0 && n_lo == '0 && n_be == '0)); // R6
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> ($stable(live) && $stable(seen))); // R7
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (live == '0 && seen == '0)); // R10
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!snap) |=> $stable(held)); // R9
  AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> (held == $past(live))); // R9
endmodule

// File: tb/tb_dbe_eye_counter.sv
`timescale 1ns/1ps
module tb_dbe_eye_counter;
  localparam int LANES  = 4;
  localparam int CNT_W  = 10;
  localparam int DLY_W  = 6;
  localparam int SKIP_W = 16;
  localparam longint CMAX = (64'd1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              clr = 1'b0, run = 1'b0, snap = 1'b0;
  logic [DLY_W-1:0]  align_dly = '0;
  logic [SKIP_W-1:0] skip_bits = '0;
  logic [LANES-1:0]  tx_bits = '0, slc_hi = '0, slc_lo = '0;
  logic [CNT_W-1:0]  up_err_cnt, up_opp_cnt, lo_err_cnt, lo_opp_cnt, bit_err_cnt;

  always #5 clk = ~clk;

  dbe_eye_counter #(.LANES(LANES), .CNT_W(CNT_W), .DLY_W(DLY_W), .SKIP_W(SKIP_W)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .run(run), .snap(snap),
    .align_dly(align_dly), .skip_bits(skip_bits), .tx_bits(tx_bits),
    .slc_hi(slc_hi), .slc_lo(slc_lo),
    .up_err_cnt(up_err_cnt), .up_opp_cnt(up_opp_cnt), .lo_err_cnt(lo_err_cnt),
    .lo_opp_cnt(lo_opp_cnt), .bit_err_cnt(bit_err_cnt)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // bench model: 0 up_err, 1 up_opp, 2 lo_err, 3 lo_opp, 4 bit_err
  longint m_live [5];
  longint m_held [5];
  longint m_seen;
  logic   m_prev;
  int     dly_words, skip_n, ptr;
  logic [LANES-1:0] hist [0:4095];

  task automatic check(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " up_err"},  up_err_cnt,  m_held[0]);
    check({tag, " up_opp"},  up_opp_cnt,  m_held[1]);
    check({tag, " lo_err"},  lo_err_cnt,  m_held[2]);
    check({tag, " lo_opp"},  lo_opp_cnt,  m_held[3]);
    check({tag, " bit_err"}, bit_err_cnt, m_held[4]);
  endtask

  task automatic do_reset(input int d, input int sk);
    rst_n = 1'b0; clr = 0; run = 0; snap = 0;
    tx_bits = '0; slc_hi = '0; slc_lo = '0;
    dly_words = d; skip_n = sk;
    align_dly = DLY_W'(d); skip_bits = SKIP_W'(sk);
    repeat (3) @(negedge clk);
    for (int k = 0; k < 5; k++) begin m_live[k] = 0; m_held[k] = 0; end
    m_seen = 0; m_prev = 1'b0; ptr = 0;
    rst_n = 1'b1;
  endtask

  // one word: r = run, s = snapshot, c = clear, ph/pl = flip percentages
  task automatic step(input logic r, input logic s, input logic c, input int ph, input int pl);
    logic [LANES-1:0] tx, al, hi, lo, fh, fl;
    int lv [LANES];
    tx = LANES'($urandom);
    hist[ptr] = tx;
    al = (ptr >= dly_words) ? hist[ptr - dly_words] : '0;
    ptr++;
    for (int i = 0; i < LANES; i++) begin
      lv[i] = int'(al[i]) + int'((i == 0) ? m_prev : al[i-1]);
      fh[i] = ($urandom_range(0, 99) < ph);
      fl[i] = ($urandom_range(0, 99) < pl);
      hi[i] = (lv[i] == 2) ^ fh[i];
      lo[i] = (lv[i] != 0) ^ fl[i];
    end
    tx_bits = tx; slc_hi = hi; slc_lo = lo; run = r; snap = s; clr = c;
    if (s) for (int k = 0; k < 5; k++) m_held[k] = m_live[k];
    if (c) begin
      for (int k = 0; k < 5; k++) m_live[k] = 0;
      m_seen = 0;
    end else if (r) begin
      for (int i = 0; i < LANES; i++) begin
        if (m_seen + i >= skip_n) begin
          if (lv[i] >= 1) begin m_live[1]++; m_live[0] += fh[i]; end
          if (lv[i] <= 1) begin m_live[3]++; m_live[2] += fl[i]; end
          m_live[4] += (fh[i] ^ fl[i]);
        end
      end
      m_seen += LANES;
      for (int k = 0; k < 5; k++) if (m_live[k] > CMAX) m_live[k] = CMAX;
    end
    m_prev = al[LANES-1];
    @(negedge clk);
  endtask

  task automatic take_snap();
    step(1'b0, 1'b1, 1'b0, 0, 0);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R11: reset state
    do_reset(0, 0);
    check_all("R11 reset");

    // R1 R2 R3 R4: clean stream, no delay
    do_reset(0, 0);
    for (int w = 0; w < 150; w++) step(1'b1, 1'b0, 1'b0, 0, 0);
    take_snap();
    check_all("R1 R2 R3 R4 clean");
    check("R1 nonzero upper opp", (up_opp_cnt > 300), 1);

    // R2 R3 R4 R5: errors with a short delay
    do_reset(7, 0);
    for (int w = 0; w < 120; w++) step(1'b1, 1'b0, 1'b0, 10, 10);
    take_snap();
    check_all("R2 R3 R4 R5 dly7");

    // R5 R6: longest delay, skip not a word multiple
    do_reset(63, 45);
    for (int w = 0; w < 100; w++) step(1'b1, 1'b0, 1'b0, 8, 15);
    take_snap();
    check_all("R5 R6 dly63 skip45");

    // R7: run low ignores a noisy stretch
    do_reset(3, 0);
    for (int w = 0; w < 50; w++) step(1'b1, 1'b0, 1'b0, 5, 5);
    take_snap();
    check_all("R7 before idle");
    for (int w = 0; w < 40; w++) step(1'b0, 1'b0, 1'b0, 50, 50);
    take_snap();
    check_all("R7 after idle");
    for (int w = 0; w < 30; w++) step(1'b1, 1'b0, 1'b0, 5, 5);

    // R9: outputs hold without snapshot
    take_snap();
    check_all("R9 snap");
    for (int w = 0; w < 20; w++) step(1'b1, 1'b0, 1'b0, 20, 20);
    check_all("R9 hold");
    take_snap();
    check_all("R9 resnap");

    // R10: clear with snapshot in the same cycle
    step(1'b1, 1'b1, 1'b1, 0, 0);
    check_all("R10 snap with clear");
    take_snap();
    check_all("R10 zero after clear");
    check("R10 up_opp zero", up_opp_cnt, 0);

    // R6 R10: skip window restarts after clear
    skip_n = 10; skip_bits = SKIP_W'(10);
    step(1'b0, 1'b0, 1'b1, 0, 0);
    for (int w = 0; w < 3; w++) step(1'b1, 1'b0, 1'b0, 100, 0);
    take_snap();
    check_all("R6 R10 partial skip");
    for (int w = 0; w < 40; w++) step(1'b1, 1'b0, 1'b0, 30, 30);
    take_snap();
    check_all("R6 R10 after skip");

    // R8: saturation under all-error traffic
    do_reset(0, 0);
    for (int w = 0; w < 500; w++) step(1'b1, 1'b0, 1'b0, 100, 100);
    take_snap();
    check_all("R8 saturate");
    check("R8 up_opp at max", up_opp_cnt, CMAX);
    check("R8 lo_err at max", lo_err_cnt, CMAX);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule